// File: doc/BRIEF.md
# Active-Low Network Interrupt Aggregator

This block gathers interrupt requests from network ports spread over several slots and keeps them as cleared bits in two 16-bit status words. Both words rest at all ones, so a zero bit marks a pending request. A peripheral raises a request by pulsing the raise strobe with a slot index and a port index. It withdraws the request by pulsing the drop strobe with the same indices. A small mapping table turns each slot into a status word and a bit offset. Here both slots use offset zero, and slot 0 feeds word 0 while slot 1 feeds word 1.

A single registered level line tells the CPU that at least one request is pending, meaning that either status word differs from all ones. The CPU reads both status words over a simple register bus. The same bus gives it a 16-bit mask register that it can read and write. The mask is stored only and does not gate the line.

The raise and drop strobes are single-cycle control pulses, not streams. No back-pressure applies to them, and every pulse is consumed in the cycle in which it is presented. Bus reads are combinational. Bus writes take effect at the clock edge.

Top module: `netirq_aggregator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both status words read 0xFFFF, the mask reads 0x0000 and `irq` is low.
- R2: A raise strobe for slot s and port p clears bit p of status word s (slot 0 goes to word 0 and slot 1 to word 1, offset 0). The change is visible in the cycle after the strobe edge.
- R3: A drop strobe for slot s and port p sets that same bit back to 1 in the cycle after the strobe edge.
- R4: `irq` is a registered level. It rises at the same clock edge at which a status word first differs from 0xFFFF. It falls at the edge at which both words return to 0xFFFF.
- R5: With `bus_en` high and `bus_wr` low, `bus_rdata` returns status word 0 at address 0x26, status word 1 at 0x28 and the mask at 0x30, all in the same cycle. Any other address, or an idle bus, returns 0x0000.
- R6: Bus writes to 0x26 and 0x28 leave both status words unchanged.
- R7: A bus write to 0x30 stores `bus_wdata` in the mask, which then holds that value until the next such write. The mask value never affects `irq`.
- R8: A raise and a drop for the same bit in the same cycle leave that bit cleared, so the raise wins.
- R9: A strobe whose slot index is 2 or 3, or whose port index is 16 or above, changes no status bit.
- R10: A raise and a drop that address different bits in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_valid | input | 1 | Single-cycle pulse that raises a request |
| raise_slot | input | 2 | Slot index for the raise |
| raise_port | input | 5 | Port index for the raise |
| drop_valid | input | 1 | Single-cycle pulse that withdraws a request |
| drop_slot | input | 2 | Slot index for the drop |
| drop_port | input | 5 | Port index for the drop |
| bus_en | input | 1 | Register bus access enable |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Registered level, high while any request is pending |

## Verification
A raise and a drop can land on the same status bit in the same cycle. The bench provokes this by driving both strobes with identical slot and port indices. The bit must end up cleared and `irq` must be high after the edge. Two further overlaps are also exercised: a raise and a drop on different bits, and a bus write to a status address alongside a strobe. A behavioural reference model applies drop first and then raise. It is compared with `irq` and `bus_rdata` on every clock, both in directed cases and in a long stretch of random traffic.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

  // Slot-to-status-word map: each slot owns the word with its own index.
  function automatic int unsigned slot_word(input int unsigned slot);
    return slot;
  endfunction

  // Bit offset of a slot's ports inside its word.
  function automatic int unsigned slot_offset(input int unsigned slot);
    if (slot == 0) return 0;
    return 0;
  endfunction

  typedef enum logic [1:0] {SEL_NONE, SEL_STATUS, SEL_MASK} bus_sel_e;

endpackage

// File: rtl/netirq_strobe_decode.sv
module netirq_strobe_decode #(
  parameter int NUM_SLOTS = 2,
  parameter int NUM_WORDS = 2,
  parameter int WORD_W    = 16,
  parameter int SLOT_W    = 2,
  parameter int PORT_W    = 5
) (
  input  logic                              valid,
  input  logic [SLOT_W-1:0]                 slot,
  input  logic [PORT_W-1:0]                 port,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  hit
);
  import netirq_pkg::*;

  int unsigned word_idx;
  int unsigned bit_idx;

  always_comb begin
    hit      = '0;
    word_idx = slot_word(int'(slot));
    bit_idx  = slot_offset(int'(slot)) + int'(port);
    if (valid && (int'(slot) < NUM_SLOTS)) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        for (int b = 0; b < WORD_W; b++) begin
          if ((word_idx == w) && (bit_idx == b)) hit[w][b] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/netirq_status_word.sv
module netirq_status_word #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] raise_hit,
  input  logic [WORD_W-1:0] drop_hit,
  output logic [WORD_W-1:0] word_q,
  output logic [WORD_W-1:0] word_nxt
);
  // Drop sets bits, raise clears them afterwards, so a raise wins a tie.
  assign word_nxt = (word_q | drop_hit) & ~raise_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '1;
    else        word_q <= word_nxt;
  end

  assert_reset_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (word_q == {WORD_W{1'b1}}));

  assert_raise_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_hit != '0) |=> ((word_q & $past(raise_hit)) == '0));

  assert_drop_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((drop_hit & ~raise_hit) != '0) |=>
      ((word_q & $past(drop_hit & ~raise_hit)) == $past(drop_hit & ~raise_hit)));

endmodule

// File: rtl/netirq_line.sv
module netirq_line #(
  parameter int NUM_WORDS = 2,
  parameter int WORD_W    = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_nxt,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q,
  output logic                             irq_q
);
  logic pending_nxt;
  logic pending_now;

  always_comb begin
    pending_nxt = 1'b0;
    pending_now = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (words_nxt[w] != {WORD_W{1'b1}}) pending_nxt = 1'b1;
      if (words_q[w]   != {WORD_W{1'b1}}) pending_now = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending_nxt;
  end

  assert_irq_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == pending_now);

endmodule

// File: rtl/netirq_regfile.sv
module netirq_regfile #(
  parameter int NUM_WORDS   = 2,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int STAT_BASE   = 'h26,
  parameter int STAT_STRIDE = 2,
  parameter int MASK_ADDR   = 'h30
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_en,
  input  logic                             bus_wr,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [WORD_W-1:0]                bus_wdata,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q,
  output logic [WORD_W-1:0]                bus_rdata
);
  import netirq_pkg::*;

  logic [WORD_W-1:0] mask_q;
  bus_sel_e          sel;
  logic [WORD_W-1:0] stat_mux;

  always_comb begin
    sel      = SEL_NONE;
    stat_mux = '0;
    if (bus_addr == ADDR_W'(MASK_ADDR)) sel = SEL_MASK;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (bus_addr == ADDR_W'(STAT_BASE + w * STAT_STRIDE)) begin
        sel      = SEL_STATUS;
        stat_mux = words_q[w];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      case (sel)
        SEL_STATUS: bus_rdata = stat_mux;
        SEL_MASK:   bus_rdata = mask_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   mask_q <= '0;
    else if (bus_en && bus_wr && sel == SEL_MASK) mask_q <= bus_wdata;
  end

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr == ADDR_W'(MASK_ADDR)) |=> (mask_q == $past(bus_wdata)));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_wr) |=> $stable(mask_q));

endmodule

// File: rtl/netirq_aggregator.sv
module netirq_aggregator #(
  parameter int NUM_SLOTS   = 2,
  parameter int NUM_WORDS   = 2,
  parameter int WORD_W      = 16,
  parameter int SLOT_W      = 2,
  parameter int PORT_W      = 5,
  parameter int ADDR_W      = 8,
  parameter int STAT_BASE   = 'h26,
  parameter int STAT_STRIDE = 2,
  parameter int MASK_ADDR   = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_valid,
  input  logic [SLOT_W-1:0] raise_slot,
  input  logic [PORT_W-1:0] raise_port,
  input  logic              drop_valid,
  input  logic [SLOT_W-1:0] drop_slot,
  input  logic [PORT_W-1:0] drop_port,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] raise_hit;
  logic [NUM_WORDS-1:0][WORD_W-1:0] drop_hit;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words_nxt;

  netirq_strobe_decode #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W),
    .SLOT_W(SLOT_W), .PORT_W(PORT_W)
  ) u_raise_dec (
    .valid(raise_valid), .slot(raise_slot), .port(raise_port), .hit(raise_hit)
  );

  netirq_strobe_decode #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W),
    .SLOT_W(SLOT_W), .PORT_W(PORT_W)
  ) u_drop_dec (
    .valid(drop_valid), .slot(drop_slot), .port(drop_port), .hit(drop_hit)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    netirq_status_word #(.WORD_W(WORD_W)) u_word (
      .clk(clk), .rst_n(rst_n),
      .raise_hit(raise_hit[w]), .drop_hit(drop_hit[w]),
      .word_q(words_q[w]), .word_nxt(words_nxt[w])
    );
  end

  netirq_line #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_line (
    .clk(clk), .rst_n(rst_n),
    .words_nxt(words_nxt), .words_q(words_q), .irq_q(irq)
  );

  netirq_regfile #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .STAT_BASE(STAT_BASE), .STAT_STRIDE(STAT_STRIDE), .MASK_ADDR(MASK_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .words_q(words_q), .bus_rdata(bus_rdata)
  );

  assert_status_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && !raise_valid && !drop_valid) |=> $stable(words_q));

  assert_out_of_range_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!drop_valid && (!raise_valid || int'(raise_slot) >= NUM_SLOTS)) |=> $stable(words_q));

endmodule

// File: tb/test_netirq_aggregator.sv
module test_netirq_aggregator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise_valid = 1'b0;
  logic [1:0]  raise_slot = '0;
  logic [4:0]  raise_port = '0;
  logic        drop_valid = 1'b0;
  logic [1:0]  drop_slot = '0;
  logic [4:0]  drop_port = '0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int m_word[2];
  int m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  netirq_aggregator i_netirq_aggregator (
    .clk(clk), .rst_n(rst_n),
    .raise_valid(raise_valid), .raise_slot(raise_slot), .raise_port(raise_port),
    .drop_valid(drop_valid), .drop_slot(drop_slot), .drop_port(drop_port),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_read(input bit en, input bit wr, input int addr);
    if (!en || wr) return 0;
    if (addr == 'h26) return m_word[0];
    if (addr == 'h28) return m_word[1];
    if (addr == 'h30) return m_mask;
    return 0;
  endfunction

  function automatic int model_irq();
    return ((m_word[0] != 'hFFFF) || (m_word[1] != 'hFFFF)) ? 1 : 0;
  endfunction

  // One clock: drive at negedge, compare the current state, then advance the model.
  task automatic step(input string tag,
                      input bit rv, input int rs, input int rp,
                      input bit dv, input int ds, input int dp,
                      input bit en, input bit wr, input int addr, input int wdata);
    @(negedge clk);
    raise_valid = rv; raise_slot = 2'(rs); raise_port = 5'(rp);
    drop_valid  = dv; drop_slot  = 2'(ds); drop_port  = 5'(dp);
    bus_en = en; bus_wr = wr; bus_addr = 8'(addr); bus_wdata = 16'(wdata);
    #1;
    check({tag, " irq"}, int'(irq), model_irq());
    check({tag, " rdata"}, int'(bus_rdata), model_read(en, wr, addr));
    @(posedge clk);
    if (dv && ds < 2 && dp < 16) m_word[ds] = m_word[ds] | (1 << dp);
    if (rv && rs < 2 && rp < 16) m_word[rs] = m_word[rs] & ~(1 << rp) & 'hFFFF;
    if (en && wr && addr == 'h30) m_mask = wdata & 'hFFFF;
  endtask

  task automatic rd(input string tag, input int addr);
    step(tag, 0, 0, 0, 0, 0, 0, 1, 0, addr, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_word[0] = 'hFFFF; m_word[1] = 'hFFFF; m_mask = 0;
    #(CLK_PERIOD * 3);
    // R1: state during reset
    check("R1 irq in reset", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1 word0", 'h26);
    rd("R1 word1", 'h28);
    rd("R1 mask", 'h30);
    // R2/R4: raises on both slots
    step("R2 raise s0p0", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd("R2 word0", 'h26);
    step("R2 raise s1p15", 1, 1, 15, 0, 0, 0, 0, 0, 0, 0);
    rd("R2 word1", 'h28);
    // R3/R4: drop both, line must fall
    step("R3 drop s0p0", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rd("R3 word0", 'h26);
    step("R3 drop s1p15", 0, 0, 0, 1, 1, 15, 0, 0, 0, 0);
    rd("R4 idle after drop", 'h28);
    // R7: mask write, then show it does not gate the line
    step("R7 write mask", 0, 0, 0, 0, 0, 0, 1, 1, 'h30, 'hA5A5);
    rd("R7 mask", 'h30);
    step("R7 mask all ones", 0, 0, 0, 0, 0, 0, 1, 1, 'h30, 'hFFFF);
    step("R7 raise with mask", 1, 1, 3, 0, 0, 0, 0, 0, 0, 0);
    rd("R7 irq unmasked", 'h30);
    step("R7 mask zero", 0, 0, 0, 0, 0, 0, 1, 1, 'h30, 0);
    rd("R7 irq with mask zero", 'h28);
    // R6: writes to status addresses ignored, also alongside a strobe
    step("R6 write word0", 0, 0, 0, 0, 0, 0, 1, 1, 'h26, 0);
    step("R6 write word1", 0, 0, 0, 0, 0, 0, 1, 1, 'h28, 'hFFFF);
    rd("R6 word1 kept", 'h28);
    step("R6 write with raise", 1, 0, 7, 0, 0, 0, 1, 1, 'h26, 'hFFFF);
    rd("R6 word0 raised", 'h26);
    // R5: unmapped and idle reads
    rd("R5 unmapped 0x24", 'h24);
    rd("R5 unmapped 0x27", 'h27);
    step("R5 idle bus", 0, 0, 0, 0, 0, 0, 0, 0, 'h26, 0);
    // R8: raise and drop of the same bit
    step("R8 same bit", 1, 0, 9, 1, 0, 9, 0, 0, 0, 0);
    rd("R8 word0", 'h26);
    step("R8 same bit pending", 1, 1, 3, 1, 1, 3, 0, 0, 0, 0);
    rd("R8 word1", 'h28);
    // R10: different bits in one cycle
    step("R10 mixed", 1, 1, 0, 1, 0, 7, 0, 0, 0, 0);
    rd("R10 word0", 'h26);
    rd("R10 word1", 'h28);
    // clear everything
    step("R3 clr a", 0, 0, 0, 1, 0, 9, 0, 0, 0, 0);
    step("R3 clr b", 0, 0, 0, 1, 1, 3, 0, 0, 0, 0);
    step("R3 clr c", 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    rd("R4 all clear", 'h26);
    // R9: out-of-range indices
    step("R9 slot2", 1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9 slot3", 1, 3, 5, 0, 0, 0, 0, 0, 0, 0);
    step("R9 port16", 1, 0, 16, 0, 0, 0, 0, 0, 0, 0);
    step("R9 port31", 1, 1, 31, 0, 0, 0, 0, 0, 0, 0);
    rd("R9 word0", 'h26);
    rd("R9 word1", 'h28);
    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      int a;
      case ($urandom % 5)
        0: a = 'h26; 1: a = 'h28; 2: a = 'h30; 3: a = 'h2A; default: a = 'h26;
      endcase
      step("R10 random", 1'($urandom % 2), int'($urandom % 4), int'($urandom % 20),
           1'($urandom % 2), int'($urandom % 4), int'($urandom % 20),
           1'($urandom % 2), 1'(($urandom % 4) == 0), a, int'($urandom % 65536));
    end
    rd("R5 final read", 'h28);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule